// File: doc/BRIEF.md
# Video Clamp and Gain Controller

This block closes the digital side of two control loops around one analog video channel. It watches the 9-bit ADC samples and does two things. During a back-porch strobe it compares each sample with a black-level target and issues clamp-up, clamp-down or hold commands to the analog clamp. Once per line it measures the sync-bottom level during a second strobe and steps an 8-bit amplifier gain code toward the level that fits the ADC range.

A white-peak guard can override the gain loop. Any sample at or near full scale forces a gain decrease at the next line update. Both loops freeze during vertical blanking. With automatic gain off, the gain code follows a static register value. The surrounding line timing logic supplies the window strobes and the blanking flag. The gain code drives the analog amplifier over a range of about 9 dB.

Top module: `vid_clamp_gain`

## Requirements
- R1: The clamp target is code 120 when `chroma_sel`=0 (luma/composite) and code 256 when `chroma_sel`=1. `clamp_cmd` is encoded 0=hold, 1=up, 2=down and is registered one clock after the sample.
- R2: While `clamp_win`=1 and `vblank`=0, a sample below target gives up, a sample above target gives down, and a sample equal to target gives hold.
- R3: While `clamp_win`=0 and `vblank`=0, `clamp_cmd` is hold on the next clock.
- R4: The sync-bottom level is the smallest sample seen while `gain_win`=1. On the first clock with `gain_win`=0 after a window, with `agc_en`=1, the gain code rises by one if that level is above 24, falls by one if it is below 8, and otherwise stays. The new value appears after that clock edge, so the gain code changes by at most one step per line.
- R5: With `peak_en`=1, any sample of 510 or more outside vertical blanking, since the previous window close, makes the next update a decrease. This holds even when the sync-bottom level asks for an increase.
- R6: With `peak_en`=0, samples at 510 or more have no effect on the gain step.
- R7: While `vblank`=1, both `clamp_cmd` and `gain_code` keep their values, and a window close gives no gain step.
- R8: With `agc_en`=0 and `vblank`=0, `gain_code` equals `static_gain` one clock later.
- R9: `gain_code` saturates at 0 (about -6 dB) and 255 (about +3 dB). A step never wraps.
- R10: After reset, `clamp_cmd` is hold and `gain_code` is 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample | input | 9 | ADC sample |
| clamp_win | input | 1 | Back-porch clamp strobe |
| gain_win | input | 1 | Sync-bottom measurement strobe |
| vblank | input | 1 | Vertical blanking flag, freezes both loops |
| chroma_sel | input | 1 | Channel type, 1 = chrominance |
| agc_en | input | 1 | Automatic gain enable |
| peak_en | input | 1 | White-peak override enable |
| static_gain | input | 8 | Gain code used when AGC is off |
| clamp_cmd | output | 2 | Clamp command: 0 hold, 1 up, 2 down |
| gain_code | output | 8 | Amplifier gain code |

## Verification
A white-peak overshoot and a sync-bottom request for more gain can meet at the same window close. That update must go down. The bench provokes this by placing a 510 or 511 sample ahead of a window whose bottom is well above the upper threshold, then checking that the code falls by one. It repeats the same line with a 509 sample and with the override disabled to show an increase instead. The other collision is blanking against a window close or a clamp strobe: the bench runs a full line with blanking held and checks that both outputs are unchanged.

// File: rtl/vcg_pkg.sv
// Shared types for the video clamp and gain controller.
package vcg_pkg;
    typedef enum logic [1:0] {
        CLAMP_HOLD = 2'd0,
        CLAMP_UP   = 2'd1,
        CLAMP_DOWN = 2'd2
    } clamp_cmd_t;
endpackage

// File: rtl/vcg_clamp_cmp.sv
// Clamp comparator: compares samples with the black-level target inside the
// back-porch window and registers an up/down/hold command.
// Assumes the window and blanking inputs are synchronous to clk.
module vcg_clamp_cmp
    import vcg_pkg::*;
#(
    parameter int SW         = 9,
    parameter int LUMA_LVL   = 120,
    parameter int CHROMA_LVL = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sample,
    input  logic          win,
    input  logic          vblank,
    input  logic          chroma,
    output clamp_cmd_t    cmd
);
    localparam logic [SW-1:0] LUMA_T   = SW'(LUMA_LVL);
    localparam logic [SW-1:0] CHROMA_T = SW'(CHROMA_LVL);

    logic [SW-1:0] target;

    // pick the target level for the channel type
    always_comb target = chroma ? CHROMA_T : LUMA_T;

    // register the clamp decision, frozen during vertical blanking
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd <= CLAMP_HOLD;
        else if (!vblank) begin
            if (!win)
                cmd <= CLAMP_HOLD;
            else if (sample < target)
                cmd <= CLAMP_UP;
            else if (sample > target)
                cmd <= CLAMP_DOWN;
            else
                cmd <= CLAMP_HOLD;
        end
    end

    assert_hold_outside_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!win && !vblank) |=> cmd == CLAMP_HOLD);
    assert_frozen_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vblank |=> $stable(cmd));
    assert_legal_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd != 2'd3);
endmodule

// File: rtl/vcg_sync_meter.sv
// Sync meter: tracks the minimum sample inside the sync-bottom window, flags
// white-peak overshoots since the last window close, and pulses line_end on
// the first clock after the window falls.
// Assumes one gain window per line.
module vcg_sync_meter #(
    parameter int SW       = 9,
    parameter int PEAK_LVL = 510
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sample,
    input  logic          win,
    input  logic          vblank,
    input  logic          peak_en,
    output logic [SW-1:0] bottom,
    output logic          peak_seen,
    output logic          line_end
);
    localparam logic [SW-1:0] PEAK_T = SW'(PEAK_LVL);

    logic win_d;
    logic peak_q;
    logic peak_now;

    // window delay for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) win_d <= 1'b0;
        else        win_d <= win;
    end

    // window close pulse
    always_comb line_end = win_d && !win;

    // overshoot in the present cycle
    always_comb peak_now = peak_en && !vblank && (sample >= PEAK_T);

    // peak flag including the present sample
    always_comb peak_seen = peak_q || peak_now;

    // running minimum inside the window
    always_ff @(posedge clk) begin
        if (!rst_n)
            bottom <= '1;
        else if (win && !vblank && (!win_d || sample < bottom))
            bottom <= sample;
    end

    // sticky peak flag, cleared at each window close
    always_ff @(posedge clk) begin
        if (!rst_n)        peak_q <= 1'b0;
        else if (line_end) peak_q <= 1'b0;
        else if (peak_now) peak_q <= 1'b1;
    end

    assert_peak_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> !peak_q);
    assert_bottom_is_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (win && win_d && !vblank) |=> bottom <= $past(bottom));
endmodule

// File: rtl/vcg_gain_step.sv
// Gain stepper: once per line moves the gain code by one step from the sync
// bottom level, with a white-peak decrease taking priority; loads the static
// gain when AGC is off. Saturates at both ends.
// Assumes line_end pulses at most once per line.
module vcg_gain_step #(
    parameter int SW       = 9,
    parameter int GW       = 8,
    parameter int BOT_HI   = 24,
    parameter int BOT_LO   = 8,
    parameter int GAIN_RST = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_end,
    input  logic [SW-1:0] bottom,
    input  logic          peak_seen,
    input  logic          agc_en,
    input  logic          vblank,
    input  logic [GW-1:0] static_gain,
    output logic [GW-1:0] gain
);
    localparam logic [GW-1:0] GMAX = '1;
    localparam logic [GW-1:0] GMIN = '0;
    localparam logic [SW-1:0] HI_T = SW'(BOT_HI);
    localparam logic [SW-1:0] LO_T = SW'(BOT_LO);

    logic want_dn;
    logic want_up;

    // direction of the line step, peak first
    always_comb begin
        want_dn = peak_seen || (bottom < LO_T);
        want_up = !want_dn && (bottom > HI_T);
    end

    // gain register with saturation and blanking freeze
    always_ff @(posedge clk) begin
        if (!rst_n)
            gain <= GW'(GAIN_RST);
        else if (!vblank) begin
            if (!agc_en)
                gain <= static_gain;
            else if (line_end && want_dn && gain != GMIN)
                gain <= gain - 1'b1;
            else if (line_end && want_up && gain != GMAX)
                gain <= gain + 1'b1;
        end
    end

    assert_frozen_gain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vblank |=> $stable(gain));
    assert_static_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!agc_en && !vblank) |=> gain == $past(static_gain));
    assert_one_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        agc_en |=> (gain == $past(gain) || gain == $past(gain) + 1'b1
                    || gain == $past(gain) - 1'b1));
    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (agc_en && gain == GMAX) |=> gain != GMIN);
    assert_peak_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && agc_en && !vblank && peak_seen && gain != GMIN)
        |=> gain == $past(gain) - 1'b1);
endmodule

// File: rtl/vid_clamp_gain.sv
// Top of the video clamp and gain controller: joins the clamp comparator,
// the sync meter and the gain stepper for one ADC channel.
// Assumes all strobes are generated in the clk domain by line timing logic.
module vid_clamp_gain
    import vcg_pkg::*;
#(
    parameter int SW       = 9,
    parameter int GW       = 8,
    parameter int GAIN_RST = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sample,
    input  logic          clamp_win,
    input  logic          gain_win,
    input  logic          vblank,
    input  logic          chroma_sel,
    input  logic          agc_en,
    input  logic          peak_en,
    input  logic [GW-1:0] static_gain,
    output logic [1:0]    clamp_cmd,
    output logic [GW-1:0] gain_code
);
    clamp_cmd_t    cmd;
    logic [SW-1:0] bottom;
    logic          peak_seen;
    logic          line_end;

    vcg_clamp_cmp #(.SW(SW)) u_clamp (
        .clk(clk), .rst_n(rst_n), .sample(sample), .win(clamp_win),
        .vblank(vblank), .chroma(chroma_sel), .cmd(cmd)
    );

    vcg_sync_meter #(.SW(SW)) u_meter (
        .clk(clk), .rst_n(rst_n), .sample(sample), .win(gain_win),
        .vblank(vblank), .peak_en(peak_en), .bottom(bottom),
        .peak_seen(peak_seen), .line_end(line_end)
    );

    vcg_gain_step #(.SW(SW), .GW(GW), .GAIN_RST(GAIN_RST)) u_gain (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .bottom(bottom),
        .peak_seen(peak_seen), .agc_en(agc_en), .vblank(vblank),
        .static_gain(static_gain), .gain(gain_code)
    );

    // expose the command as a plain vector
    always_comb clamp_cmd = cmd;
endmodule

// File: tb/tb_vid_clamp_gain.sv
module tb_vid_clamp_gain;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [8:0] sample;
    logic       clamp_win, gain_win, vblank, chroma_sel, agc_en, peak_en;
    logic [7:0] static_gain;
    logic [1:0] clamp_cmd;
    logic [7:0] gain_code;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int exp_g;

    always #10 clk = ~clk;

    vid_clamp_gain dut (
        .clk(clk), .rst_n(rst_n), .sample(sample), .clamp_win(clamp_win),
        .gain_win(gain_win), .vblank(vblank), .chroma_sel(chroma_sel),
        .agc_en(agc_en), .peak_en(peak_en), .static_gain(static_gain),
        .clamp_cmd(clamp_cmd), .gain_code(gain_code)
    );

    // {chroma, clamp_win, vblank, sample, static, exp_cmd, exp_gain}; agc off
    localparam int NV = 13;
    localparam logic [29:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b0, 9'd100, 8'd50,  2'd1, 8'd50},
        {1'b0, 1'b1, 1'b0, 9'd120, 8'd60,  2'd0, 8'd60},
        {1'b0, 1'b1, 1'b0, 9'd121, 8'd61,  2'd2, 8'd61},
        {1'b1, 1'b1, 1'b0, 9'd255, 8'd62,  2'd1, 8'd62},
        {1'b1, 1'b1, 1'b0, 9'd256, 8'd63,  2'd0, 8'd63},
        {1'b1, 1'b1, 1'b0, 9'd300, 8'd64,  2'd2, 8'd64},
        {1'b0, 1'b0, 1'b0, 9'd0,   8'd65,  2'd0, 8'd65},
        {1'b0, 1'b1, 1'b0, 9'd500, 8'd66,  2'd2, 8'd66},
        {1'b0, 1'b1, 1'b1, 9'd0,   8'd99,  2'd2, 8'd66},
        {1'b0, 1'b0, 1'b1, 9'd5,   8'd10,  2'd2, 8'd66},
        {1'b0, 1'b1, 1'b0, 9'd5,   8'd10,  2'd1, 8'd10},
        {1'b1, 1'b1, 1'b0, 9'd511, 8'd255, 2'd2, 8'd255},
        {1'b0, 1'b0, 1'b0, 9'd0,   8'd0,   2'd0, 8'd0}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one line: optional peak sample, a three-sample gain window, then close
    task automatic line(int bot, int pk, bit vb);
        vblank = vb;
        gain_win = 1'b0;
        sample = (pk >= 0) ? 9'(pk) : 9'd200;
        step();
        gain_win = 1'b1;
        sample = 9'(bot + 30); step();
        sample = 9'(bot);      step();
        sample = 9'(bot + 10); step();
        gain_win = 1'b0;
        sample = 9'd200;
        step();
        vblank = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sample = '0; clamp_win = 0; gain_win = 0; vblank = 0;
        chroma_sel = 0; agc_en = 1; peak_en = 0; static_gain = 8'd7;
        repeat (3) step();
        check("R10 reset cmd", clamp_cmd, 0);
        check("R10 reset gain", gain_code, 128);
        rst_n = 1'b1;
        agc_en = 1'b0;

        // R1 R2 R3 R7 R8 table walk
        for (int i = 0; i < NV; i++) begin
            chroma_sel  = VEC[i][29];
            clamp_win   = VEC[i][28];
            vblank      = VEC[i][27];
            sample      = VEC[i][26:18];
            static_gain = VEC[i][17:10];
            step();
            check($sformatf("R1/R2/R3/R7/R8 vec%0d cmd", i), clamp_cmd, VEC[i][9:8]);
            check($sformatf("R7/R8 vec%0d gain", i), gain_code, VEC[i][7:0]);
        end
        clamp_win = 1'b0; vblank = 1'b0; chroma_sel = 1'b0;

        // AGC stepping, R4
        static_gain = 8'd128; step();
        agc_en = 1'b1; exp_g = 128;
        line(40, -1, 0); exp_g = 129; check("R4 bottom high up", gain_code, exp_g);
        line(2, -1, 0);  exp_g = 128; check("R4 bottom low down", gain_code, exp_g);
        line(16, -1, 0); check("R4 in band hold", gain_code, exp_g);
        line(24, -1, 0); check("R4 upper edge hold", gain_code, exp_g);
        line(25, -1, 0); exp_g = 129; check("R4 above upper up", gain_code, exp_g);
        line(8, -1, 0);  check("R4 lower edge hold", gain_code, exp_g);
        line(7, -1, 0);  exp_g = 128; check("R4 below lower down", gain_code, exp_g);

        // R5 peak override and R6 disable
        peak_en = 1'b1;
        line(40, 511, 0); exp_g = 127; check("R5 peak beats up", gain_code, exp_g);
        line(40, 509, 0); exp_g = 128; check("R5 509 no peak", gain_code, exp_g);
        line(40, 510, 0); exp_g = 127; check("R5 510 limit", gain_code, exp_g);
        peak_en = 1'b0;
        line(40, 511, 0); exp_g = 128; check("R6 peak disabled", gain_code, exp_g);

        // R7 whole line in blanking, clamp strobe also frozen
        clamp_win = 1'b1;
        line(40, -1, 1);
        check("R7 gain frozen", gain_code, exp_g);
        check("R7 clamp frozen", clamp_cmd, 0);
        clamp_win = 1'b0;

        // R9 saturation
        agc_en = 1'b0; static_gain = 8'd254; step();
        agc_en = 1'b1;
        line(40, -1, 0); check("R9 reach 255", gain_code, 255);
        line(40, -1, 0); check("R9 hold 255", gain_code, 255);
        agc_en = 1'b0; static_gain = 8'd1; step();
        agc_en = 1'b1;
        line(2, -1, 0); check("R9 reach 0", gain_code, 0);
        line(2, -1, 0); check("R9 hold 0", gain_code, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule